// File: doc/BRIEF.md
# Per-Thread Squash Resolver

This block sits at the retirement end of a multithreaded out-of-order pipeline. It decides, for each hardware thread and each cycle, whether a squash happens and where it lands. Three sources can request a squash. A trap squash and an external-context squash both flush the whole thread. An execute-stage squash comes from a resolved branch or a replay and carries a sequence number and four qualifier flags. The block keeps the youngest valid sequence number of every thread. It uses that number to reject execute-stage squashes that are younger than a squash already taken.

For every accepted squash the block computes two points. The first is the point at which the reorder buffer stops squashing, with the branch delay slot either kept or removed depending on the mispredict direction and the branch type. The second is the done sequence number reported to the front of the pipeline. It emits a one-cycle squash pulse with these values and a redirect PC. The thread then stays in a squashing status until the reorder buffer reports that its walk is finished. The walk itself happens outside this block. All outputs are registered and appear one clock after the request.

Top module: `squash_resolver`

## Requirements
- R1: When a trap squash and a context squash of the same thread arrive in the same cycle, the trap squash is the one performed, and `illegal_o` for that thread is high for exactly the following cycle. A lone request of either kind leaves `illegal_o` low.
- R2: A trap or context squash sets both `rob_sq_seq_o` and `done_seq_o` to the head sequence number minus one, or to 0 when `rob_empty_i` is high. It clears `ds_squash_o`, drives `resume_pc_i` on `redirect_pc_o`, and resets the thread's youngest sequence number to 0.
- R3: An execute-stage squash is accepted only when all of the following hold: the thread is not waiting on a trap, its sequence number is less than or equal to the thread's youngest sequence number (unsigned), and no trap or context squash arrives for that thread in the same cycle. A rejected request produces no pulse and changes no state.
- R4: On an accepted squash with mispredict, taken and conditional-delay-slot all high, `rob_sq_seq_o` equals the squash sequence number and `ds_squash_o` is 1.
- R5: On an accepted squash with mispredict high and taken or conditional-delay-slot low, `rob_sq_seq_o` equals the squash sequence number plus one and `ds_squash_o` is 0.
- R6: On an accepted squash with mispredict low, `rob_sq_seq_o` equals the squash sequence number and `ds_squash_o` is 0.
- R7: With the include flag set, both `done_seq_o` and `rob_sq_seq_o` are one lower than R4 to R6 give. `done_seq_o` is otherwise the squash sequence number. All sequence arithmetic wraps modulo 2^SEQ_W.
- R8: After any accepted squash, the thread's youngest sequence number becomes the reported `done_seq_o`. `squashing_o` is high from the cycle of the pulse on, every cycle, and falls one cycle after `rob_sq_done_i` is seen high while squashing.
- R9: `sq_pulse_o` is high for exactly one cycle per accepted squash, one clock after the request. An accepted execute-stage squash drives `ex_redirect_pc_i` on `redirect_pc_o`.
- R10: Each thread's `mispred_cnt_o` increments by one on every accepted execute-stage squash with mispredict high, and wraps modulo 2^CNT_W.
- R11: `trap_arm_i` places the thread in a trap-waiting status. Only a trap or context squash leaves that status.
- R12: `alloc_valid_i` loads `alloc_seq_i` as the thread's youngest sequence number. An accepted squash in the same cycle takes precedence.
- R13: Threads are independent. A request on one thread changes no output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_sq_i | input | THREADS | Trap squash request per thread |
| ctx_sq_i | input | THREADS | External-context squash request per thread |
| trap_arm_i | input | THREADS | Thread enters trap-waiting status |
| resume_pc_i | input | THREADS*PC_W | Redirect PC for trap/context squashes |
| rob_empty_i | input | THREADS | Reorder buffer holds nothing for the thread |
| rob_head_seq_i | input | THREADS*SEQ_W | Sequence number at the buffer head |
| rob_sq_done_i | input | THREADS | Reorder-buffer squash walk finished |
| alloc_valid_i | input | THREADS | New youngest sequence number valid |
| alloc_seq_i | input | THREADS*SEQ_W | Youngest allocated sequence number |
| ex_sq_valid_i | input | THREADS | Execute-stage squash request |
| ex_sq_seq_i | input | THREADS*SEQ_W | Sequence number of the squashing instruction |
| ex_mispred_i | input | THREADS | Request is a branch mispredict |
| ex_taken_i | input | THREADS | Mispredicted branch was predicted taken |
| ex_cond_ds_i | input | THREADS | Branch is a conditional delay-slot branch |
| ex_incl_i | input | THREADS | Squash includes the squashing instruction |
| ex_redirect_pc_i | input | THREADS*PC_W | Redirect PC for execute-stage squashes |
| sq_pulse_o | output | THREADS | One-cycle accepted-squash pulse |
| rob_sq_seq_o | output | THREADS*SEQ_W | Reorder-buffer squash stop point |
| done_seq_o | output | THREADS*SEQ_W | Done sequence number for the pipeline |
| ds_squash_o | output | THREADS | Delay slot is squashed |
| redirect_pc_o | output | THREADS*PC_W | Redirect PC of the squash |
| squashing_o | output | THREADS | Thread is in squashing status |
| illegal_o | output | THREADS | Trap and context squash collided |
| mispred_cnt_o | output | THREADS*CNT_W | Accepted mispredict count per thread |

## Verification
On every cycle, the checker confirms several relations. It ties the collision flag to the prior cycle's request pair. It checks that every trap or context request yields a pulse with the delay-slot flag clear, that a pulse never appears outside squashing status, and that the delay-slot flag never appears without a pulse. It also checks that squashing status only ends after a walk-done report. The arithmetic of the stop and done points, the older-only filter against the youngest sequence number, trap-waiting rejection and counter wrap are only visible in the bench's sweeps. Those sweeps cover every flag combination across sequence numbers below, at and above the youngest value.

// File: rtl/sqr_pkg.sv
package sqr_pkg;

    typedef enum logic [1:0] {
        TH_RUN      = 2'd0,
        TH_SQUASH   = 2'd1,
        TH_TRAPWAIT = 2'd2
    } th_state_e;

    typedef struct packed {
        logic mispred;
        logic taken;
        logic cond_ds;
        logic incl;
    } ex_flags_t;

    function automatic logic slot_squashed(input ex_flags_t f);
        return f.mispred & f.taken & f.cond_ds;
    endfunction

    function automatic logic slot_kept(input ex_flags_t f);
        return f.mispred & ~(f.taken & f.cond_ds);
    endfunction

endpackage

// File: rtl/sqr_point_calc.sv
module sqr_point_calc
    import sqr_pkg::*;
#(
    parameter int SEQ_W = 8
) (
    input  logic [SEQ_W-1:0] seq_i,
    input  ex_flags_t        flags_i,
    output logic [SEQ_W-1:0] rob_pt_o,
    output logic [SEQ_W-1:0] done_pt_o,
    output logic             ds_o
);
    localparam logic [SEQ_W-1:0] ONE = {{(SEQ_W-1){1'b0}}, 1'b1};

    logic [SEQ_W-1:0] dec;
    logic [SEQ_W-1:0] inc;

    always_comb begin
        dec       = flags_i.incl ? ONE : '0;
        inc       = slot_kept(flags_i) ? ONE : '0;
        done_pt_o = seq_i - dec;
        rob_pt_o  = seq_i + inc - dec;
        ds_o      = slot_squashed(flags_i);
    end
endmodule

// File: rtl/sqr_thread_ctl.sv
module sqr_thread_ctl
    import sqr_pkg::*;
#(
    parameter int SEQ_W = 8,
    parameter int PC_W  = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_i,
    input  logic             ctx_i,
    input  logic             arm_i,
    input  logic [PC_W-1:0]  resume_pc_i,
    input  logic             rob_empty_i,
    input  logic [SEQ_W-1:0] rob_head_i,
    input  logic             rob_done_i,
    input  logic             alloc_valid_i,
    input  logic [SEQ_W-1:0] alloc_seq_i,
    input  logic             ex_valid_i,
    input  logic [SEQ_W-1:0] ex_seq_i,
    input  ex_flags_t        ex_flags_i,
    input  logic [PC_W-1:0]  ex_pc_i,
    output logic             pulse_o,
    output logic [SEQ_W-1:0] rob_pt_o,
    output logic [SEQ_W-1:0] done_pt_o,
    output logic             ds_o,
    output logic [PC_W-1:0]  pc_o,
    output logic             squashing_o,
    output logic             illegal_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [SEQ_W-1:0] ONE = {{(SEQ_W-1){1'b0}}, 1'b1};

    th_state_e        state_q;
    logic [SEQ_W-1:0] youngest_q;
    logic             flush_req;
    logic             ex_ok;
    logic [SEQ_W-1:0] flush_pt;
    logic [SEQ_W-1:0] calc_rob;
    logic [SEQ_W-1:0] calc_done;
    logic             calc_ds;

    sqr_point_calc #(.SEQ_W(SEQ_W)) u_calc (
        .seq_i     (ex_seq_i),
        .flags_i   (ex_flags_i),
        .rob_pt_o  (calc_rob),
        .done_pt_o (calc_done),
        .ds_o      (calc_ds)
    );

    always_comb begin
        flush_req = trap_i | ctx_i;
        flush_pt  = rob_empty_i ? '0 : (rob_head_i - ONE);
        ex_ok     = ex_valid_i && (state_q != TH_TRAPWAIT)
                    && (ex_seq_i <= youngest_q) && !flush_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= TH_RUN;
            youngest_q <= '0;
            pulse_o    <= 1'b0;
            rob_pt_o   <= '0;
            done_pt_o  <= '0;
            ds_o       <= 1'b0;
            pc_o       <= '0;
            illegal_o  <= 1'b0;
            cnt_o      <= '0;
        end else begin
            pulse_o   <= flush_req | ex_ok;
            illegal_o <= trap_i & ctx_i;
            if (flush_req) begin
                state_q    <= TH_SQUASH;
                youngest_q <= '0;
                rob_pt_o   <= flush_pt;
                done_pt_o  <= flush_pt;
                ds_o       <= 1'b0;
                pc_o       <= resume_pc_i;
            end else if (ex_ok) begin
                state_q    <= TH_SQUASH;
                youngest_q <= calc_done;
                rob_pt_o   <= calc_rob;
                done_pt_o  <= calc_done;
                ds_o       <= calc_ds;
                pc_o       <= ex_pc_i;
                if (ex_flags_i.mispred) begin
                    cnt_o <= cnt_o + 1'b1;
                end
            end else begin
                ds_o <= 1'b0;
                if (alloc_valid_i) begin
                    youngest_q <= alloc_seq_i;
                end
                if (arm_i) begin
                    state_q <= TH_TRAPWAIT;
                end else if (state_q == TH_SQUASH && rob_done_i) begin
                    state_q <= TH_RUN;
                end
            end
        end
    end

    assign squashing_o = (state_q == TH_SQUASH);
endmodule

// File: rtl/squash_resolver.sv
module squash_resolver
    import sqr_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int SEQ_W   = 8,
    parameter int PC_W    = 16,
    parameter int CNT_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [THREADS-1:0]       trap_sq_i,
    input  logic [THREADS-1:0]       ctx_sq_i,
    input  logic [THREADS-1:0]       trap_arm_i,
    input  logic [THREADS*PC_W-1:0]  resume_pc_i,
    input  logic [THREADS-1:0]       rob_empty_i,
    input  logic [THREADS*SEQ_W-1:0] rob_head_seq_i,
    input  logic [THREADS-1:0]       rob_sq_done_i,
    input  logic [THREADS-1:0]       alloc_valid_i,
    input  logic [THREADS*SEQ_W-1:0] alloc_seq_i,
    input  logic [THREADS-1:0]       ex_sq_valid_i,
    input  logic [THREADS*SEQ_W-1:0] ex_sq_seq_i,
    input  logic [THREADS-1:0]       ex_mispred_i,
    input  logic [THREADS-1:0]       ex_taken_i,
    input  logic [THREADS-1:0]       ex_cond_ds_i,
    input  logic [THREADS-1:0]       ex_incl_i,
    input  logic [THREADS*PC_W-1:0]  ex_redirect_pc_i,
    output logic [THREADS-1:0]       sq_pulse_o,
    output logic [THREADS*SEQ_W-1:0] rob_sq_seq_o,
    output logic [THREADS*SEQ_W-1:0] done_seq_o,
    output logic [THREADS-1:0]       ds_squash_o,
    output logic [THREADS*PC_W-1:0]  redirect_pc_o,
    output logic [THREADS-1:0]       squashing_o,
    output logic [THREADS-1:0]       illegal_o,
    output logic [THREADS*CNT_W-1:0] mispred_cnt_o
);
    localparam int SEQ_BUS = THREADS * SEQ_W;
    localparam int PC_BUS  = THREADS * PC_W;

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        ex_flags_t flags;
        assign flags = '{mispred: ex_mispred_i[t], taken: ex_taken_i[t],
                         cond_ds: ex_cond_ds_i[t], incl: ex_incl_i[t]};

        sqr_thread_ctl #(.SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_thr (
            .clk           (clk),
            .rst           (rst),
            .trap_i        (trap_sq_i[t]),
            .ctx_i         (ctx_sq_i[t]),
            .arm_i         (trap_arm_i[t]),
            .resume_pc_i   (resume_pc_i[t*PC_W +: PC_W]),
            .rob_empty_i   (rob_empty_i[t]),
            .rob_head_i    (rob_head_seq_i[t*SEQ_W +: SEQ_W]),
            .rob_done_i    (rob_sq_done_i[t]),
            .alloc_valid_i (alloc_valid_i[t]),
            .alloc_seq_i   (alloc_seq_i[t*SEQ_W +: SEQ_W]),
            .ex_valid_i    (ex_sq_valid_i[t]),
            .ex_seq_i      (ex_sq_seq_i[t*SEQ_W +: SEQ_W]),
            .ex_flags_i    (flags),
            .ex_pc_i       (ex_redirect_pc_i[t*PC_W +: PC_W]),
            .pulse_o       (sq_pulse_o[t]),
            .rob_pt_o      (rob_sq_seq_o[t*SEQ_W +: SEQ_W]),
            .done_pt_o     (done_seq_o[t*SEQ_W +: SEQ_W]),
            .ds_o          (ds_squash_o[t]),
            .pc_o          (redirect_pc_o[t*PC_W +: PC_W]),
            .squashing_o   (squashing_o[t]),
            .illegal_o     (illegal_o[t]),
            .cnt_o         (mispred_cnt_o[t*CNT_W +: CNT_W])
        );
    end

    if (SEQ_BUS != $bits(rob_sq_seq_o) || PC_BUS != $bits(redirect_pc_o)) begin : g_bad
        initial $error("bus width mismatch");
    end
endmodule

// File: rtl/squash_resolver_chk.sv
module squash_resolver_chk #(
    parameter int THREADS = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [THREADS-1:0] trap_sq_i,
    input logic [THREADS-1:0] ctx_sq_i,
    input logic [THREADS-1:0] rob_sq_done_i,
    input logic [THREADS-1:0] sq_pulse_o,
    input logic [THREADS-1:0] ds_squash_o,
    input logic [THREADS-1:0] squashing_o,
    input logic [THREADS-1:0] illegal_o
);
    // R1
    collide_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (illegal_o == $past(trap_sq_i & ctx_sq_i)));

    // R2
    flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(trap_sq_i | ctx_sq_i) & ~sq_pulse_o) == '0));

    // R2
    flush_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(trap_sq_i | ctx_sq_i) & ds_squash_o) == '0));

    // R8
    pulse_in_squash_chk: assert property (@(posedge clk) disable iff (rst)
        (sq_pulse_o & ~squashing_o) == '0);

    // R8
    leave_squash_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
        (($past(squashing_o) & ~squashing_o & ~$past(rob_sq_done_i)) == '0));

    // R4
    slot_needs_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (ds_squash_o & ~sq_pulse_o) == '0);
endmodule

bind squash_resolver squash_resolver_chk #(.THREADS(THREADS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .trap_sq_i     (trap_sq_i),
    .ctx_sq_i      (ctx_sq_i),
    .rob_sq_done_i (rob_sq_done_i),
    .sq_pulse_o    (sq_pulse_o),
    .ds_squash_o   (ds_squash_o),
    .squashing_o   (squashing_o),
    .illegal_o     (illegal_o)
);

// File: tb/squash_resolver_bench.sv
module squash_resolver_bench;
    localparam int T  = 2;
    localparam int SW = 5;
    localparam int PW = 8;
    localparam int CW = 4;
    localparam int SMASK = (1 << SW) - 1;
    localparam int CMASK = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [T-1:0]    trap_sq, ctx_sq, trap_arm, rob_empty, rob_done, alloc_v;
    logic [T-1:0]    ex_v, ex_mis, ex_tak, ex_cond, ex_inc;
    logic [T*PW-1:0] resume_pc, ex_pc;
    logic [T*SW-1:0] rob_head, alloc_seq, ex_seq;
    logic [T-1:0]    sq_pulse, ds_sq, squashing, illegal;
    logic [T*SW-1:0] rob_sq_seq, done_seq;
    logic [T*PW-1:0] redir_pc;
    logic [T*CW-1:0] mcnt;

    int n_checks = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    squash_resolver #(.THREADS(T), .SEQ_W(SW), .PC_W(PW), .CNT_W(CW)) u_squash_resolver (
        .clk(clk), .rst(rst), .trap_sq_i(trap_sq), .ctx_sq_i(ctx_sq),
        .trap_arm_i(trap_arm), .resume_pc_i(resume_pc), .rob_empty_i(rob_empty),
        .rob_head_seq_i(rob_head), .rob_sq_done_i(rob_done),
        .alloc_valid_i(alloc_v), .alloc_seq_i(alloc_seq),
        .ex_sq_valid_i(ex_v), .ex_sq_seq_i(ex_seq), .ex_mispred_i(ex_mis),
        .ex_taken_i(ex_tak), .ex_cond_ds_i(ex_cond), .ex_incl_i(ex_inc),
        .ex_redirect_pc_i(ex_pc), .sq_pulse_o(sq_pulse), .rob_sq_seq_o(rob_sq_seq),
        .done_seq_o(done_seq), .ds_squash_o(ds_sq), .redirect_pc_o(redir_pc),
        .squashing_o(squashing), .illegal_o(illegal), .mispred_cnt_o(mcnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        trap_sq = '0; ctx_sq = '0; trap_arm = '0; rob_done = '0;
        alloc_v = '0; ex_v = '0; ex_mis = '0; ex_tak = '0; ex_cond = '0; ex_inc = '0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic alloc(input int t, input int y);
        alloc_v[t] = 1'b1;
        alloc_seq[t*SW +: SW] = SW'(y);
        step();
    endtask

    task automatic finish_walk(input int t);
        rob_done[t] = 1'b1;
        step();
        chk(squashing[t] == 1'b0, "R8 leave squash", int'(squashing[t]), 0);
    endtask

    task automatic ex_req(input int t, input int s, input int fl, input int pc);
        ex_v[t] = 1'b1;
        ex_seq[t*SW +: SW] = SW'(s);
        ex_mis[t] = fl[3]; ex_tak[t] = fl[2]; ex_cond[t] = fl[1]; ex_inc[t] = fl[0];
        ex_pc[t*PW +: PW] = PW'(pc);
        step();
    endtask

    task automatic ex_case(input int y, input int s, input int fl);
        bit acc, mis, tak, cnd, inc;
        int erob, edone, eds;
        mis = fl[3]; tak = fl[2]; cnd = fl[1]; inc = fl[0];
        acc = (s <= y);
        edone = (s - int'(inc)) & SMASK;
        erob = (s + int'(mis && !(tak && cnd)) - int'(inc)) & SMASK;
        eds = int'(mis && tak && cnd);
        alloc(0, y);
        ex_req(0, s, fl, (s * 7 + fl) & 8'hff);
        chk(sq_pulse[0] == acc, "R3 accept filter", int'(sq_pulse[0]), int'(acc));
        chk(sq_pulse[1] == 1'b0, "R13 other thread", int'(sq_pulse[1]), 0);
        if (acc) begin
            if (mis) exp_cnt = (exp_cnt + 1) & CMASK;
            if (eds != 0)
                chk(int'(rob_sq_seq[SW-1:0]) == erob && ds_sq[0], "R4 slot squashed",
                    int'(rob_sq_seq[SW-1:0]), erob);
            else if (mis)
                chk(int'(rob_sq_seq[SW-1:0]) == erob && !ds_sq[0], "R5 slot kept",
                    int'(rob_sq_seq[SW-1:0]), erob);
            else
                chk(int'(rob_sq_seq[SW-1:0]) == erob && !ds_sq[0], "R6 no mispredict",
                    int'(rob_sq_seq[SW-1:0]), erob);
            chk(int'(done_seq[SW-1:0]) == edone, "R7 done point",
                int'(done_seq[SW-1:0]), edone);
            chk(int'(redir_pc[PW-1:0]) == ((s * 7 + fl) & 8'hff), "R9 redirect pc",
                int'(redir_pc[PW-1:0]), (s * 7 + fl) & 8'hff);
            chk(squashing[0] == 1'b1, "R8 squashing", int'(squashing[0]), 1);
        end
        chk(int'(mcnt[CW-1:0]) == exp_cnt, "R10 mispredict count",
            int'(mcnt[CW-1:0]), exp_cnt);
        step();
        chk(sq_pulse[0] == 1'b0, "R9 single pulse", int'(sq_pulse[0]), 0);
        if (acc) begin
            chk(squashing[0] == 1'b1, "R8 hold squash", int'(squashing[0]), 1);
            finish_walk(0);
        end
    endtask

    initial begin
        idle();
        resume_pc = '0; ex_pc = '0; rob_head = '0; alloc_seq = '0; ex_seq = '0;
        rob_empty = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        chk(sq_pulse == '0 && squashing == '0 && illegal == '0 && mcnt == '0,
            "reset state", int'(sq_pulse), 0);

        // R4 R5 R6 R7 R3 sweep over flags and sequence relations
        foreach (ex_case_ys[i]) begin end
        for (int yi = 0; yi < 3; yi++) begin
            for (int fl = 0; fl < 16; fl++) begin
                for (int d = 0; d < 3; d++) begin
                    int y, s;
                    y = (yi == 0) ? 3 : ((yi == 1) ? 17 : 30);
                    s = (d == 0) ? y - 2 : ((d == 1) ? y : y + 1);
                    ex_case(y, s, fl);
                end
            end
        end

        // R8 youngest follows the adjusted done point
        alloc(0, 10);
        ex_req(0, 8, 4'b0001, 1);
        finish_walk(0);
        ex_req(0, 8, 0, 2);
        chk(sq_pulse[0] == 1'b0, "R8 youngest bound reject", int'(sq_pulse[0]), 0);
        ex_req(0, 7, 0, 3);
        chk(sq_pulse[0] == 1'b1, "R8 youngest bound accept", int'(sq_pulse[0]), 1);
        step();
        finish_walk(0);

        // R12 squash beats allocation in the same cycle
        alloc(0, 9);
        alloc_v[0] = 1'b1; alloc_seq[SW-1:0] = SW'(20);
        ex_req(0, 5, 0, 4);
        chk(sq_pulse[0] == 1'b1, "R12 squash with alloc", int'(sq_pulse[0]), 1);
        step();
        finish_walk(0);
        ex_req(0, 6, 0, 5);
        chk(sq_pulse[0] == 1'b0, "R12 alloc ignored", int'(sq_pulse[0]), 0);

        // R2 trap on non-empty buffer, same-cycle execute squash dropped (R3)
        alloc(0, 25);
        rob_empty[0] = 1'b0; rob_head[SW-1:0] = SW'(12);
        resume_pc[PW-1:0] = 8'hA5;
        trap_sq[0] = 1'b1;
        ex_req(0, 20, 4'b1000, 9);
        chk(sq_pulse[0] && int'(rob_sq_seq[SW-1:0]) == 11, "R2 head minus one",
            int'(rob_sq_seq[SW-1:0]), 11);
        chk(int'(done_seq[SW-1:0]) == 11 && !ds_sq[0], "R2 done point",
            int'(done_seq[SW-1:0]), 11);
        chk(int'(redir_pc[PW-1:0]) == 8'hA5, "R2 resume pc", int'(redir_pc[PW-1:0]), 8'hA5);
        chk(int'(mcnt[CW-1:0]) == exp_cnt, "R3 dropped under trap", int'(mcnt[CW-1:0]), exp_cnt);
        chk(illegal[0] == 1'b0, "R1 lone trap", int'(illegal[0]), 0);
        step();
        finish_walk(0);
        ex_req(0, 1, 0, 6);
        chk(sq_pulse[0] == 1'b0, "R2 youngest zero reject", int'(sq_pulse[0]), 0);
        ex_req(0, 0, 0, 6);
        chk(sq_pulse[0] == 1'b1 && int'(rob_sq_seq[SW-1:0]) == 0, "R2 youngest zero accept",
            int'(rob_sq_seq[SW-1:0]), 0);
        step();
        finish_walk(0);

        // R2 context squash with empty buffer
        rob_empty[0] = 1'b1;
        ctx_sq[0] = 1'b1;
        step();
        chk(sq_pulse[0] && int'(rob_sq_seq[SW-1:0]) == 0 && int'(done_seq[SW-1:0]) == 0,
            "R2 empty buffer", int'(rob_sq_seq[SW-1:0]), 0);
        step();
        finish_walk(0);

        // R1 collision on thread 1
        rob_empty[1] = 1'b0; rob_head[SW +: SW] = SW'(4);
        resume_pc[PW +: PW] = 8'h3C;
        trap_sq[1] = 1'b1; ctx_sq[1] = 1'b1;
        step();
        chk(illegal[1] == 1'b1 && sq_pulse[1], "R1 collision flag", int'(illegal[1]), 1);
        chk(int'(rob_sq_seq[SW +: SW]) == 3, "R1 trap handled", int'(rob_sq_seq[SW +: SW]), 3);
        chk(sq_pulse[0] == 1'b0 && illegal[0] == 1'b0, "R13 thread zero untouched",
            int'(sq_pulse[0]), 0);
        step();
        chk(illegal[1] == 1'b0, "R1 flag one cycle", int'(illegal[1]), 0);
        finish_walk(1);

        // R11 trap wait rejects execute squashes until a trap squash
        alloc(0, 30);
        trap_arm[0] = 1'b1;
        step();
        ex_req(0, 2, 0, 7);
        chk(sq_pulse[0] == 1'b0, "R11 trap wait reject", int'(sq_pulse[0]), 0);
        rob_done[0] = 1'b1;
        ex_req(0, 2, 0, 7);
        chk(sq_pulse[0] == 1'b0, "R11 walk done ignored", int'(sq_pulse[0]), 0);
        trap_sq[0] = 1'b1;
        step();
        step();
        finish_walk(0);
        alloc(0, 30);
        ex_req(0, 2, 0, 7);
        chk(sq_pulse[0] == 1'b1, "R11 released by trap", int'(sq_pulse[0]), 1);
        step();
        finish_walk(0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    int ex_case_ys[1];

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule